// File: doc/BRIEF.md
# Single-Wire Debug Serial Receiver

This block is the target-side receive path of a debug link that runs over a single wire and is clocked by the host. It watches one open-drain line that an external host drives without any relation to the target clock. The line passes through a synchronizer. Each falling edge that the host makes on the line opens a bit time. A fixed number of target cycles after the edge is perceived, the block takes the line level as the bit value. Bits are shifted into a word register with the most significant bit first. When the last bit of a word arrives, the block presents the word and pulses a strobe.

A gap counter runs while a word is partly received. If the host leaves too long a gap between two bit edges, the counter discards the partial word and pulses a timeout. Edges that arrive while a bit is still waiting for its sample point are ignored.

The host sets the pace of the link, so the target has no way to hold off the next bit. For that reason the word output has a valid strobe and no ready input. `word_valid_o` is high for exactly one cycle. `word_data_o` keeps its value until the next word completes, so a consumer may take it on the strobe or at any later cycle before the next strobe.

Top module: `sdl_rx`

## Requirements
- R1: While `rst` is high at a clock edge, the block clears everything it holds. From the next cycle on, `word_valid_o` and `timeout_o` are 0 and `word_data_o` is all zeros.
- R2: A bit is taken from the line level seen 10 cycles after the target perceives the falling edge. Counting from the first rising clock edge after the host pulls the line low (A0), the bit is the line level at edge A10. So a low pulse of at most 10 cycles gives 1, and a low pulse of 11 cycles or more gives 0.
- R3: Bits are assembled most significant first. The first bit of a word lands in `word_data_o[WORD_W-1]` and the last bit lands in bit 0. The default is `WORD_W` = 8.
- R4: `word_valid_o` is high for exactly one cycle, starting 13 clock edges after the host pulls the line low for the last bit of a word (visible after edge A12). `word_data_o` changes only together with that strobe.
- R5: A falling edge that arrives while the current bit has not yet been sampled has no effect on the assembled word or on its timing.
- R6: If 512 cycles pass after the last accepted edge while a word is incomplete, `timeout_o` pulses for one cycle. This is visible after edge A514 of the last bit. The partial word is discarded, and the next word assembles from its first bit.
- R7: No timeout occurs while no word is in progress, that is, after reset or after a completed word.
- R8: A reset in the middle of a word discards the partial word. The next word is received correctly and no timeout follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Target clock |
| rst | input | 1 | Synchronous active-high reset |
| line_i | input | 1 | Level of the shared debug line, asynchronous to `clk`, idle high |
| word_data_o | output | WORD_W | Last completed word, held between strobes |
| word_valid_o | output | 1 | One-cycle strobe marking a new word |
| timeout_o | output | 1 | One-cycle pulse when a partial word is dropped |

## Verification
The hardest behaviour to reach from the ports is an edge that lands inside the sampling window of a bit. An ordinary host never produces one. The bench therefore sends 1-bits carrying an extra short low glitch placed after the true edge but before the sample point, and checks that both the word value and the strobe cycle match the glitch-free case. The exact sample point is pinned down by words built entirely from 10-cycle and 11-cycle low pulses. The exact timeout cycle is reached by stopping a word after three bits and leaving the line idle.

// File: rtl/sdl_rx_pkg.sv
package sdl_rx_pkg;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_WAIT = 1'b1
  } phase_e;

  // Width of a counter that must hold values 0..n
  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/sdl_line_sync.sv
module sdl_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic level_o,
  output logic fall_o
);

  // pipe[STAGES-1] is the synchronized level; pipe[STAGES] is its previous value
  logic [STAGES:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= '1;
    else     pipe <= {pipe[STAGES-1:0], line_i};
  end

  assign level_o = pipe[STAGES-1];
  assign fall_o  = pipe[STAGES] & ~pipe[STAGES-1];

endmodule

// File: rtl/sdl_bit_sampler.sv
module sdl_bit_sampler
  import sdl_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_OFS = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic fall_i,
  input  logic level_i,
  output logic accept_o,
  output logic busy_o,
  output logic sample_o,
  output logic bit_o
);

  localparam int unsigned CW = cnt_bits(SAMPLE_OFS);

  phase_e        phase;
  logic [CW-1:0] cnt;

  assign accept_o = fall_i && (phase == PH_IDLE);
  assign busy_o   = (phase == PH_WAIT);
  assign sample_o = (phase == PH_WAIT) && (cnt == CW'(SAMPLE_OFS));
  assign bit_o    = level_i;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      phase <= PH_IDLE;
      cnt   <= '0;
    end else if (accept_o) begin
      phase <= PH_WAIT;
      cnt   <= CW'(1);
    end else if (phase == PH_WAIT) begin
      if (sample_o) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

endmodule

// File: rtl/sdl_word_shifter.sv
module sdl_word_shifter
  import sdl_rx_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              sample_i,
  input  logic              bit_i,
  output logic [WORD_W-1:0] data_o,
  output logic              valid_o,
  output logic              partial_o
);

  localparam int unsigned BCW = cnt_bits(WORD_W - 1);

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] shnext;
  logic [BCW-1:0]    bcnt;
  logic              last_bit;

  assign shnext    = {shreg[WORD_W-2:0], bit_i};
  assign last_bit  = (bcnt == BCW'(WORD_W - 1));
  assign partial_o = (bcnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '0;
      bcnt    <= '0;
      data_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (clear_i) begin
        shreg <= '0;
        bcnt  <= '0;
      end else if (sample_i) begin
        if (last_bit) begin
          data_o  <= shnext;
          valid_o <= 1'b1;
          shreg   <= '0;
          bcnt    <= '0;
        end else begin
          shreg <= shnext;
          bcnt  <= bcnt + BCW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/sdl_gap_watchdog.sv
module sdl_gap_watchdog
  import sdl_rx_pkg::*;
#(
  parameter int unsigned LIMIT = 512
) (
  input  logic clk,
  input  logic rst,
  input  logic restart_i,
  input  logic active_i,
  output logic expire_o,
  output logic timeout_o
);

  localparam int unsigned CW = cnt_bits(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire_o = active_i && !restart_i && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      timeout_o <= 1'b0;
    end else begin
      timeout_o <= expire_o;
      if (restart_i || expire_o || !active_i) cnt <= '0;
      else                                   cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/sdl_rx.sv
module sdl_rx #(
  parameter int unsigned WORD_W      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMPLE_OFS  = 10,
  parameter int unsigned GAP_LIMIT   = 512
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_i,
  output logic [WORD_W-1:0] word_data_o,
  output logic              word_valid_o,
  output logic              timeout_o
);

  logic level_s;
  logic fall_s;
  logic accept_s;
  logic busy_s;
  logic sample_s;
  logic bit_s;
  logic partial_s;
  logic expire_s;

  sdl_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .line_i  (line_i),
    .level_o (level_s),
    .fall_o  (fall_s)
  );

  sdl_bit_sampler #(.SAMPLE_OFS(SAMPLE_OFS)) u_smp (
    .clk      (clk),
    .rst      (rst),
    .clear_i  (expire_s),
    .fall_i   (fall_s),
    .level_i  (level_s),
    .accept_o (accept_s),
    .busy_o   (busy_s),
    .sample_o (sample_s),
    .bit_o    (bit_s)
  );

  sdl_word_shifter #(.WORD_W(WORD_W)) u_shf (
    .clk       (clk),
    .rst       (rst),
    .clear_i   (expire_s),
    .sample_i  (sample_s),
    .bit_i     (bit_s),
    .data_o    (word_data_o),
    .valid_o   (word_valid_o),
    .partial_o (partial_s)
  );

  sdl_gap_watchdog #(.LIMIT(GAP_LIMIT)) u_wdg (
    .clk       (clk),
    .rst       (rst),
    .restart_i (accept_s),
    .active_i  (busy_s | partial_s),
    .expire_o  (expire_s),
    .timeout_o (timeout_o)
  );

endmodule

// File: rtl/sdl_rx_chk.sv
module sdl_rx_chk #(
  parameter int unsigned WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              valid,
  input logic              tmo,
  input logic [WORD_W-1:0] data,
  input logic              fall,
  input logic              busy
);

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!valid && !tmo)); // R1

  AST_BIT_STARTS_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(fall)); // R2

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid); // R4

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!valid && !$past(rst)) |-> $stable(data)); // R4

  AST_TMO_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tmo |=> !tmo); // R6

  AST_TMO_NOT_WITH_WORD: assert property (@(posedge clk) disable iff (rst)
    !(tmo && valid)); // R6

endmodule

bind sdl_rx sdl_rx_chk #(.WORD_W(WORD_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .valid (word_valid_o),
  .tmo   (timeout_o),
  .data  (word_data_o),
  .fall  (fall_s),
  .busy  (busy_s)
);

// File: tb/sim_sdl_rx.sv
`timescale 1ns/1ps
module sim_sdl_rx;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         line = 1'b1;
  logic [W-1:0] word_data;
  logic         word_valid;
  logic         tmo;

  int  nvec = 0;
  int  nbad = 0;
  int  pcnt = 0;
  int  drop_p = 0;
  int  vcount = 0;
  int  vat = 0;
  int  tcount = 0;
  int  tat = 0;
  logic [W-1:0] vdata = '0;
  bit  done = 1'b0;

  always #4 clk = ~clk;

  sdl_rx #(.WORD_W(W)) u0 (
    .clk          (clk),
    .rst          (rst),
    .line_i       (line),
    .word_data_o  (word_data),
    .word_valid_o (word_valid),
    .timeout_o    (tmo)
  );

  always @(posedge clk) pcnt <= pcnt + 1;

  always @(negedge clk) begin
    if (word_valid) begin vcount <= vcount + 1; vdata <= word_data; vat <= pcnt; end
    if (tmo)        begin tcount <= tcount + 1; tat <= pcnt; end
  end

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act != exp) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one bit time of 16 cycles with a low pulse of low_len cycles
  task automatic send_len(input int low_len, input bit glitch);
    line   = 1'b0;
    drop_p = pcnt;
    if (!glitch) begin
      tick(low_len);
      line = 1'b1;
      tick(16 - low_len);
    end else begin
      tick(4); line = 1'b1;
      tick(2); line = 1'b0;
      tick(2); line = 1'b1;
      tick(8);
    end
  endtask

  task automatic send_word(input logic [W-1:0] w, input bit glitch, input int nbits);
    for (int i = W - 1; i >= W - nbits; i--)
      send_len(w[i] ? 4 : 13, glitch && w[i]);
  endtask

  task automatic word_case(input logic [W-1:0] w, input bit glitch, input string req);
    int v0;
    v0 = vcount;
    send_word(w, glitch, W);
    chk({req, " count"}, vcount, v0 + 1);
    chk({req, " data"}, int'(vdata), int'(w));
    chk("R4 strobe cycle", vat, drop_p + 13);
  endtask

  initial begin
    int v0;
    int t0;
    logic [W-1:0] held;
    tick(4);
    rst = 1'b0;
    tick(1);
    chk("R1 valid", int'(word_valid), 0);
    chk("R1 timeout", int'(tmo), 0);
    chk("R1 data", int'(word_data), 0);

    // R7: idle after reset, no timeout
    t0 = tcount;
    tick(600);
    chk("R7 idle after reset", tcount, t0);

    // R2 R3 R4: exhaustive sweep of all word values
    for (int w = 0; w < (1 << W); w++)
      word_case(W'(w), 1'b0, "R3 sweep");

    // R2: sample point boundary, 10-cycle low gives 1, 11-cycle gives 0
    v0 = vcount;
    for (int i = 0; i < W; i++) send_len(10, 1'b0);
    chk("R2 low10 count", vcount, v0 + 1);
    chk("R2 low10 data", int'(vdata), (1 << W) - 1);
    for (int i = 0; i < W; i++) send_len(11, 1'b0);
    chk("R2 low11 data", int'(vdata), 0);
    for (int i = 0; i < W; i++) send_len((i % 2 == 0) ? 10 : 11, 1'b0);
    chk("R2 mixed data", int'(vdata), 8'hAA);

    // R5: glitch edges inside the sampling window are ignored
    for (int w = 0; w < (1 << W); w += 7)
      word_case(W'(w), 1'b1, "R5 glitch");

    // R4: data holds during a partial word
    held = word_data;
    send_word(8'h5A, 1'b0, 3);
    chk("R4 data hold", int'(word_data), int'(held));

    // R6: timeout on partial word
    v0 = vcount;
    t0 = tcount;
    tick(600);
    chk("R6 timeout count", tcount, t0 + 1);
    chk("R6 timeout cycle", tat, drop_p + 515);
    chk("R6 no word", vcount, v0);
    word_case(8'h3C, 1'b0, "R6 after timeout");

    // R7: no timeout after a completed word
    t0 = tcount;
    tick(700);
    chk("R7 idle after word", tcount, t0);

    // R8: reset mid-word
    send_word(8'hFF, 1'b0, 4);
    rst = 1'b1;
    tick(2);
    rst = 1'b0;
    chk("R8 data cleared", int'(word_data), 0);
    t0 = tcount;
    tick(600);
    chk("R8 no timeout", tcount, t0);
    word_case(8'h0F, 1'b0, "R8 after reset");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

endmodule